// File: doc/BRIEF.md
# Configuration EEPROM Loader

After reset this block reads the whole contents of a small serial configuration EEPROM. It drives the chip select, clock and data-in pins of a 64 x 16-bit serial EEPROM directly, and it samples the EEPROM's data-out pin. Every phase of the serial clock lasts a fixed number of core clock cycles, and a parameter sets that number. Each read opens with a start bit and an 8-bit read command, and then 16 data bits are clocked back.

The block does not keep a copy of the image. It adds every word into a running 16-bit checksum and keeps only the bytes that carry settings. The image counts as valid when the checksum of all 64 words equals the signature. When it is valid, the block publishes three settings taken from the image:

- the adapter's bus ID;
- a tag-queue depth, which is a power of two;
- an active-negation enable.

When the image is not valid, the outputs keep their built-in defaults. A one-cycle done pulse marks the end of the load. After that the serial pins stay idle until the next reset.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held and right after it, ee_cs_o, ee_sk_o, done_o, valid_o and act_neg_o are 0, scsi_id_o equals DEF_ID (7) and tag_depth_o equals DEF_TAGS.
- R2: Every word is read in its own chip-select frame. Between frames, chip select is low for exactly one phase, and the serial clock is low whenever chip select is low.
- R3: Each frame begins with 9 command bits on ee_di_o: a start bit of 1, then the byte 0x80 plus the word address, MSB first. The data-in value changes only while the serial clock is low.
- R4: Word addresses 0 to 63 are read once each, in ascending order, which makes 64 frames per load.
- R5: After the command, 16 data bits are taken MSB first. Each bit is sampled from ee_do_i at the end of the phase in which the serial clock is high.
- R6: Each high and low phase of the serial clock lasts exactly DIV core clock cycles.
- R7: valid_o is 1 after the load when the modulo-65536 sum of the 64 words equals 0x1234.
- R8: With a valid image, scsi_id_o is image byte 0x40. Byte 2n is the low half of word n and byte 2n+1 is the high half, so byte 0x40 is the low byte of word 0x20.
- R9: With a valid image, tag_depth_o is 2 shifted left by image byte 0x43 (the high byte of word 0x21), truncated to TAG_W bits.
- R10: With a valid image, act_neg_o is bit 3 of image byte 0x41 (the high byte of word 0x20).
- R11: When the checksum does not match, valid_o stays 0 and the three settings keep their defaults.
- R12: done_o is high for exactly one cycle per reset, in the same cycle in which the results appear. Afterwards the outputs hold and chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low; a load starts when it is released |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial command data to the EEPROM |
| ee_do_i | input | 1 | Serial read data from the EEPROM |
| done_o | output | 1 | One-cycle pulse when the load finishes |
| valid_o | output | 1 | Image checksum matched |
| scsi_id_o | output | 8 | Adapter bus ID |
| tag_depth_o | output | TAG_W | Tag-queue depth |
| act_neg_o | output | 1 | Active-negation enable |

## Verification
The assertions take four things for granted:

- DIV is at least 2.
- Reset is applied once before each load.
- The EEPROM changes ee_do_i only in response to serial clock edges.
- The EEPROM leaves the done and hold behaviour untouched, since those depend only on frame counting.

The EEPROM model in the bench places each data bit just after a rising serial clock edge, a full phase before the design samples it. The bench uses DIV=4 and resets the block between images, so every load starts from a clean, idle interface.

// File: rtl/cel_pkg.sv
package cel_pkg;
  localparam int unsigned WW = 16;
  localparam int unsigned AW = 6;
  localparam logic [1:0] READ_OP = 2'b10;        // upper bits of 0x80 | addr
  localparam logic [3:0] CMD_LAST = 4'd8;
  localparam logic [3:0] DATA_LAST = 4'd15;
  localparam logic [WW-1:0] SIGNATURE = 16'h1234;

  localparam logic [7:0] ID_BYTE = 8'h40;
  localparam logic [7:0] MODE_BYTE = 8'h41;
  localparam logic [7:0] TAG_BYTE = 8'h43;
  localparam int unsigned AN_BIT = 3;

  // bit positions inside the 16-bit word that holds each byte
  localparam int unsigned ID_LSB = ID_BYTE[0] ? 8 : 0;
  localparam int unsigned TAG_LSB = TAG_BYTE[0] ? 8 : 0;
  localparam int unsigned AN_POS = (MODE_BYTE[0] ? 8 : 0) + AN_BIT;

  typedef enum logic [1:0] {ST_GAP, ST_CMD, ST_DATA, ST_IDLE} seq_st_e;
endpackage

// File: rtl/cel_prescaler.sv
module cel_prescaler #(
  parameter int unsigned DIV = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cel_sequencer.sv
module cel_sequencer
  import cel_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ee_do_i,
  output logic          ee_cs_o,
  output logic          ee_sk_o,
  output logic          ee_di_o,
  output logic          word_vld_o,
  output logic          last_o,
  output logic [WW-1:0] word_o,
  output logic [AW-1:0] addr_o
);
  seq_st_e       st_q;
  logic          ph_q;
  logic [3:0]    bit_q;
  logic [AW-1:0] addr_q;
  logic [8:0]    cmd_q;
  logic [WW-1:0] shf_q;
  logic          vld_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_GAP;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      shf_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      // advance address after the word is handed over; the gap phase covers it
      if (vld_q && !last_q) addr_q <= addr_q + 1'b1;
      if (tick_i) begin
        unique case (st_q)
          ST_GAP: begin
            st_q  <= ST_CMD;
            ph_q  <= 1'b0;
            bit_q <= '0;
            cmd_q <= {1'b1, READ_OP, addr_q};
          end
          ST_CMD: begin
            if (!ph_q) ph_q <= 1'b1;
            else begin
              ph_q  <= 1'b0;
              cmd_q <= {cmd_q[7:0], 1'b0};
              if (bit_q == CMD_LAST) begin
                st_q  <= ST_DATA;
                bit_q <= '0;
              end else bit_q <= bit_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (!ph_q) ph_q <= 1'b1;
            else begin
              ph_q  <= 1'b0;
              shf_q <= {shf_q[WW-2:0], ee_do_i};
              if (bit_q == DATA_LAST) begin
                vld_q  <= 1'b1;
                last_q <= &addr_q;
                st_q   <= (&addr_q) ? ST_IDLE : ST_GAP;
              end else bit_q <= bit_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ee_cs_o    = (st_q == ST_CMD) || (st_q == ST_DATA);
  assign ee_sk_o    = ee_cs_o & ph_q;
  assign ee_di_o    = (st_q == ST_CMD) & cmd_q[8];
  assign word_vld_o = vld_q;
  assign last_o     = last_q;
  assign word_o     = shf_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/cel_image.sv
module cel_image
  import cel_pkg::*;
#(
  parameter int unsigned      TAG_W    = 16,
  parameter logic [7:0]       DEF_ID   = 8'd7,
  parameter logic [TAG_W-1:0] DEF_TAGS = TAG_W'(32)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_vld_i,
  input  logic             last_i,
  input  logic [WW-1:0]    word_i,
  input  logic [AW-1:0]    addr_i,
  output logic             done_o,
  output logic             valid_o,
  output logic [7:0]       id_o,
  output logic [TAG_W-1:0] tags_o,
  output logic             an_o
);
  logic [WW-1:0]    sum_q, sum_d;
  logic [7:0]       id_b_q, tag_b_q;
  logic             an_b_q;
  logic             done_q, valid_q, an_q;
  logic [7:0]       id_q;
  logic [TAG_W-1:0] tags_q;

  assign sum_d = sum_q + word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      id_b_q  <= '0;
      tag_b_q <= '0;
      an_b_q  <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      id_q    <= DEF_ID;
      tags_q  <= DEF_TAGS;
      an_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (word_vld_i) begin
        sum_q <= sum_d;
        if (addr_i == ID_BYTE[AW:1])   id_b_q  <= word_i[ID_LSB +: 8];
        if (addr_i == TAG_BYTE[AW:1])  tag_b_q <= word_i[TAG_LSB +: 8];
        if (addr_i == MODE_BYTE[AW:1]) an_b_q  <= word_i[AN_POS];
        if (last_i) begin
          done_q  <= 1'b1;
          valid_q <= (sum_d == SIGNATURE);
          if (sum_d == SIGNATURE) begin
            id_q   <= id_b_q;
            tags_q <= TAG_W'(2) << tag_b_q;
            an_q   <= an_b_q;
          end
        end
      end
    end
  end

  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign id_o    = id_q;
  assign tags_o  = tags_q;
  assign an_o    = an_q;
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cel_pkg::*;
#(
  parameter int unsigned      DIV      = 20000,
  parameter int unsigned      TAG_W    = 16,
  parameter logic [7:0]       DEF_ID   = 8'd7,
  parameter logic [TAG_W-1:0] DEF_TAGS = TAG_W'(32)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             ee_cs_o,
  output logic             ee_sk_o,
  output logic             ee_di_o,
  input  logic             ee_do_i,
  output logic             done_o,
  output logic             valid_o,
  output logic [7:0]       scsi_id_o,
  output logic [TAG_W-1:0] tag_depth_o,
  output logic             act_neg_o
);
  logic          tick, word_vld, last;
  logic [WW-1:0] word;
  logic [AW-1:0] addr;

  cel_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  cel_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .ee_do_i   (ee_do_i),
    .ee_cs_o   (ee_cs_o),
    .ee_sk_o   (ee_sk_o),
    .ee_di_o   (ee_di_o),
    .word_vld_o(word_vld),
    .last_o    (last),
    .word_o    (word),
    .addr_o    (addr)
  );

  cel_image #(.TAG_W(TAG_W), .DEF_ID(DEF_ID), .DEF_TAGS(DEF_TAGS)) u_img (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_vld_i(word_vld),
    .last_i    (last),
    .word_i    (word),
    .addr_i    (addr),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .id_o      (scsi_id_o),
    .tags_o    (tag_depth_o),
    .an_o      (act_neg_o)
  );
endmodule

// File: rtl/cel_chk.sv
module cel_chk #(
  parameter int unsigned      DIV      = 20000,
  parameter int unsigned      TAG_W    = 16,
  parameter logic [7:0]       DEF_ID   = 8'd7,
  parameter logic [TAG_W-1:0] DEF_TAGS = TAG_W'(32)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ee_cs_o,
  input logic             ee_sk_o,
  input logic             ee_di_o,
  input logic             done_o,
  input logic             valid_o,
  input logic [7:0]       scsi_id_o,
  input logic [TAG_W-1:0] tag_depth_o,
  input logic             act_neg_o
);
  logic [31:0] hi_cnt_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      hi_cnt_q <= ee_sk_o ? hi_cnt_q + 1 : '0;
      if (done_o) seen_q <= 1'b1;
    end
  end

  assert_sk_framed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sk_o);
  assert_di_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> $stable(ee_di_o));
  assert_phase_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> hi_cnt_q < DIV);
  assert_defaults_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (scsi_id_o == DEF_ID) && (tag_depth_o == DEF_TAGS) && !act_neg_o);
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_once_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !seen_q);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(valid_o) && $stable(scsi_id_o) && $stable(tag_depth_o) && $stable(act_neg_o));
  assert_idle_after_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> !ee_cs_o);
endmodule

bind cfg_eeprom_loader cel_chk #(
  .DIV(DIV), .TAG_W(TAG_W), .DEF_ID(DEF_ID), .DEF_TAGS(DEF_TAGS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ee_cs_o    (ee_cs_o),
  .ee_sk_o    (ee_sk_o),
  .ee_di_o    (ee_di_o),
  .done_o     (done_o),
  .valid_o    (valid_o),
  .scsi_id_o  (scsi_id_o),
  .tag_depth_o(tag_depth_o),
  .act_neg_o  (act_neg_o)
);

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb;
  localparam int unsigned DIV = 4;
  localparam int unsigned TAG_W = 16;
  localparam logic [7:0] DEF_ID = 8'd7;
  localparam logic [15:0] DEF_TAGS = 16'd32;
  localparam logic [15:0] SIG = 16'h1234;

  typedef struct {
    logic        v;
    logic [7:0]  id;
    logic [15:0] tags;
    logic        an;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di, ee_do;
  logic done, valid, an;
  logic [7:0] id;
  logic [15:0] tags;

  always #4 clk = ~clk;

  cfg_eeprom_loader #(.DIV(DIV), .TAG_W(TAG_W), .DEF_ID(DEF_ID), .DEF_TAGS(DEF_TAGS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di),
    .ee_do_i(ee_do), .done_o(done), .valid_o(valid), .scsi_id_o(id),
    .tag_depth_o(tags), .act_neg_o(an)
  );

  int checks = 0, errors = 0;
  logic [15:0] mem [64];
  logic [8:0] exp_cmd_q[$];
  res_t exp_res_q[$];
  int done_cnt = 0, frames = 0, gap_err = 0, skhi_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model and command scoreboard (R3, R4, R5)
  int bitn = 0;
  logic start_b = 1'b0;
  logic [7:0] cmd_sh = '0;
  int cur_addr = 0;
  initial ee_do = 1'b0;

  always @(posedge ee_cs) bitn = 0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (bitn == 0) start_b = ee_di;
      else if (bitn < 9) cmd_sh = {cmd_sh[6:0], ee_di};
      if (bitn == 8) begin
        cur_addr = int'(cmd_sh[5:0]);
        if (exp_cmd_q.size() == 0)
          chk(1'b0, "R4", "unexpected frame", longint'({start_b, cmd_sh}), 0);
        else begin
          logic [8:0] e;
          e = exp_cmd_q.pop_front();
          chk({start_b, cmd_sh} == e, "R3", "command bits", longint'({start_b, cmd_sh}), longint'(e));
        end
      end
      if (bitn >= 9 && bitn < 25) ee_do = mem[cur_addr][24 - bitn];
      bitn++;
    end
  end

  // timing and result monitor
  int skhi = 0, gapc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      skhi = 0;
      gapc = 0;
    end else begin
      if (ee_sk) skhi++;
      else begin
        if (skhi != 0 && skhi != DIV) skhi_err++;
        skhi = 0;
      end
      if (!ee_cs) gapc++;
      else begin
        if (gapc != 0) begin
          if (frames > 0 && gapc != DIV) gap_err++;
          frames++;
        end
        gapc = 0;
      end
      if (done) begin
        done_cnt++;
        if (exp_res_q.size() == 0) chk(1'b0, "R12", "unexpected done", 1, 0);
        else begin
          res_t r;
          r = exp_res_q.pop_front();
          chk(valid == r.v, "R7 R11", "valid_o", valid, r.v);
          chk(id == r.id, "R5 R8", "scsi_id_o", id, r.id);
          chk(tags == r.tags, "R9", "tag_depth_o", tags, r.tags);
          chk(an == r.an, "R10", "act_neg_o", an, r.an);
        end
      end
    end
  end

  task automatic run_case(input logic [7:0] id_b, input logic [7:0] mode_b,
                          input logic [7:0] tag_b, input bit corrupt);
    logic [15:0] sum;
    res_t r;
    sum = '0;
    for (int i = 0; i < 63; i++) begin
      mem[i] = 16'(i * 16'h0913) ^ 16'h5A3C;
      if (i == 32) mem[i] = {mode_b, id_b};
      if (i == 33) mem[i] = {tag_b, 8'h2D};
      sum = sum + mem[i];
    end
    mem[63] = SIG - sum + (corrupt ? 16'd1 : 16'd0);
    r.v    = !corrupt;
    r.id   = corrupt ? DEF_ID : id_b;
    r.tags = corrupt ? DEF_TAGS : 16'(32'd2 << tag_b);
    r.an   = corrupt ? 1'b0 : mode_b[3];
    for (int a = 0; a < 64; a++) exp_cmd_q.push_back({1'b1, 8'h80 | 8'(a)});
    exp_res_q.push_back(r);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk, "R1", "serial pins in reset", {ee_cs, ee_sk}, 0);
    chk(!done && !valid && !an, "R1", "flags in reset", {done, valid, an}, 0);
    chk(id == DEF_ID && tags == DEF_TAGS, "R1", "default settings", {id, tags}, {DEF_ID, DEF_TAGS});
    done_cnt = 0; frames = 0; gap_err = 0; skhi_err = 0;
    @(negedge clk) rst_n = 1'b1;
    while (done_cnt == 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
    chk(!ee_cs, "R12", "chip select idle after load", ee_cs, 0);
    chk(valid == r.v && id == r.id && tags == r.tags && an == r.an, "R12", "held results",
        {valid, id, tags, an}, {r.v, r.id, r.tags, r.an});
    chk(exp_cmd_q.size() == 0 && frames == 64, "R4", "frames read", frames, 64);
    chk(gap_err == 0, "R2", "gap phase length errors", gap_err, 0);
    chk(skhi_err == 0, "R6", "clock high phase errors", skhi_err, 0);
  endtask

  initial begin
    run_case(8'h05, 8'h08, 8'h03, 1'b0);  // valid, depth 16, negation on
    run_case(8'h02, 8'h3F, 8'h04, 1'b1);  // checksum off by one -> defaults
    run_case(8'h03, 8'hF7, 8'h00, 1'b0);  // negation bit clear, depth 2
    run_case(8'hC1, 8'h08, 8'h0F, 1'b0);  // depth truncates to 0 in 16 bits
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule